// File: doc/BRIEF.md
# Parameter-Set Sequencer With Triggers

This block is the control engine of an offload accelerator. Software fills a table of sixteen configuration sets and programs a start index, a stop index and a loop count. Once enabled, the sequencer fetches each set in turn over a read port into the table and latches it into working registers. It then holds off until the trigger chosen by that set has arrived. Next it launches the compute datapath with a one-cycle start pulse and waits for the datapath's done pulse. Each finished set may raise a processor interrupt and a pulse on one of sixteen DMA channel trigger lines.

Trigger events come from three sources: a software trigger pulse, an ADC buffer switch pulse and a 16-bit vector of DMA completion pulses. They are latched until a set consumes them, so an event that arrives early is not lost and an event launches no more than one run. A guarded enable code and a two-write software reset keep a single corrupted write from starting or resetting the engine.

Top module: `pset_sequencer`

## Requirements
- R1: After reset, busy, irq, calc_start, dma_chan_trig and done_status are all zero. The engine runs only while the enable register (address 0, bits [2:0]) holds 3'b111. Any other value prevents any start. Changing it to another value while running returns the engine to idle.
- R2: Sets are fetched over tbl_rd_en/tbl_rd_addr (data returned one cycle later). The order begins at the start index (address 2, bits [3:0]) and goes up by one, wrapping from 15 to 0. After the stop index (address 2, bits [7:4]), the walk returns to the start index.
- R3: Loop count (address 3, bits [11:0]): 0 or 1 gives one pass from start to stop. N from 2 to 4094 gives N passes. 12'hFFF repeats until the engine is disabled or reset.
- R4: Table word bits [2:0] select the trigger. 000 starts at once. 001 waits for sw_trig. 010 waits for adc_buf_switch when buffer sharing (address 1, bit 0) is on, and otherwise starts at once. 011 waits on dma_done_trig bit sel (word bits [6:3]). Codes 1xx start at once.
- R5: Trigger pulses are held until consumed. Starting a set clears only the source it used (only bit sel for DMA), so one pulse launches exactly one run and other pending bits remain.
- R6: When a set completes, irq pulses for one cycle if word bit 7 is set. If word bit 8 is set, dma_chan_trig pulses for one cycle with only bit chan (word bits [12:9]) high.
- R7: Completing set k sets done_status[k]. The bit stays set until a write to address 4 with bit k set clears it.
- R8: Writing 3'b111 and then 3'b000 to address 5 is a software reset. It stops the engine and clears the enable register, done_status and all pending triggers. Any other write to address 5 cancels a pending 3'b111.
- R9: busy is high from the first fetch until the last set of the last pass completes. calc_start is a single-cycle pulse, given once per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| tbl_rd_en | output | 1 | Table read request |
| tbl_rd_addr | output | 4 | Index of the set being fetched |
| tbl_rd_data | input | 13 | Set word, valid the cycle after the request |
| calc_start | output | 1 | Start pulse to the compute datapath |
| calc_done | input | 1 | Done pulse from the compute datapath |
| sw_trig | input | 1 | Software trigger pulse |
| adc_buf_switch | input | 1 | ADC buffer switch pulse |
| dma_done_trig | input | 16 | DMA completion trigger pulses |
| irq | output | 1 | Processor interrupt pulse |
| dma_chan_trig | output | 16 | DMA channel trigger pulses |
| busy | output | 1 | Sequence in progress |
| done_status | output | 16 | Per-set completion flags |

## Verification
The bound checker checks several rules on every cycle. calc_start is one cycle wide and occurs only while busy. dma_chan_trig never has more than one bit high. irq follows a datapath done pulse. A done flag falls only after a clear or reset write. A disabled engine drops busy. The walk order, the loop count, the wrap, the waiting of each trigger mode and the one-run-per-pulse consumption appear only over a sequence of events. The bench's scenarios show these through fetch logs, start counts and the scoreboard of completion pulses.

// File: rtl/pset_pkg.sv
package pset_pkg;
  localparam int IDX_W  = 4;
  localparam int CH_W   = 4;
  localparam int LOOP_W = 12;
  localparam int REG_AW = 3;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] A_ENABLE  = 3'd0;
  localparam logic [REG_AW-1:0] A_SHARE   = 3'd1;
  localparam logic [REG_AW-1:0] A_RANGE   = 3'd2;
  localparam logic [REG_AW-1:0] A_LOOP    = 3'd3;
  localparam logic [REG_AW-1:0] A_DONECLR = 3'd4;
  localparam logic [REG_AW-1:0] A_SRST    = 3'd5;

  localparam logic [2:0] TM_NOW = 3'b000;
  localparam logic [2:0] TM_SW  = 3'b001;
  localparam logic [2:0] TM_ADC = 3'b010;
  localparam logic [2:0] TM_DMA = 3'b011;

  typedef struct packed {
    logic [CH_W-1:0] chan;
    logic            dma_en;
    logic            irq_en;
    logic [CH_W-1:0] sel;
    logic [2:0]      mode;
  } set_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOAD, ST_WAIT, ST_RUN, ST_DONE
  } seq_state_t;

  function automatic logic [IDX_W-1:0] step_index(
      input logic [IDX_W-1:0] cur, input logic [IDX_W-1:0] first,
      input logic [IDX_W-1:0] last);
    return (cur == last) ? first : IDX_W'(cur + 1'b1);
  endfunction

  function automatic logic final_pass(input logic [LOOP_W-1:0] pass,
                                      input logic [LOOP_W-1:0] loops);
    if (&loops)                 return 1'b0;
    if (loops <= LOOP_W'(1))    return 1'b1;
    return pass == LOOP_W'(loops - 1'b1);
  endfunction

  function automatic logic [(1<<CH_W)-1:0] chan_pulse(input logic [CH_W-1:0] ch);
    logic [(1<<CH_W)-1:0] v;
    v = '0;
    v[ch] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pset_ctrl_regs.sv
module pset_ctrl_regs
  import pset_pkg::*;
#(
  parameter int SETS_W = IDX_W,
  parameter int CNT_W  = LOOP_W,
  parameter int AW     = REG_AW,
  parameter int DW     = REG_DW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     set_done,
  input  logic [SETS_W-1:0]        done_idx,
  output logic                     eng_on,
  output logic                     share_on,
  output logic [SETS_W-1:0]        start_idx,
  output logic [SETS_W-1:0]        stop_idx,
  output logic [CNT_W-1:0]         loop_val,
  output logic [(1<<SETS_W)-1:0]   done_bits,
  output logic                     sreset,
  output logic                     clr_any
);
  localparam int NSETS = 1 << SETS_W;

  logic [2:0] enable_q;
  logic       armed_q;
  logic       wr_srst, wr_clr;
  logic [NSETS-1:0] set_mask;

  assign wr_srst  = wr_en && (wr_addr == A_SRST);
  assign wr_clr   = wr_en && (wr_addr == A_DONECLR);
  assign sreset   = wr_srst && armed_q && (wr_data[2:0] == 3'b000);
  assign clr_any  = sreset || (wr_clr && (|wr_data[NSETS-1:0]));
  assign eng_on   = (enable_q == 3'b111);
  assign set_mask = set_done ? chan_pulse(CH_W'(done_idx)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q  <= '0;
      share_on  <= 1'b0;
      start_idx <= '0;
      stop_idx  <= '0;
      loop_val  <= '0;
      armed_q   <= 1'b0;
    end else if (sreset) begin
      enable_q <= '0;
      armed_q  <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_ENABLE: enable_q <= wr_data[2:0];
        A_SHARE:  share_on <= wr_data[0];
        A_RANGE: begin
          start_idx <= wr_data[SETS_W-1:0];
          stop_idx  <= wr_data[2*SETS_W-1:SETS_W];
        end
        A_LOOP:   loop_val <= wr_data[CNT_W-1:0];
        default: ;
      endcase
      if (wr_srst) armed_q <= (wr_data[2:0] == 3'b111);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_bits <= '0;
    else if (sreset)  done_bits <= '0;
    else if (wr_clr)  done_bits <= (done_bits & ~wr_data[NSETS-1:0]) | set_mask;
    else              done_bits <= done_bits | set_mask;
  end
endmodule

// File: rtl/pset_trig_unit.sv
module pset_trig_unit
  import pset_pkg::*;
#(
  parameter int SEL_W = CH_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sreset,
  input  logic                   sw_trig_in,
  input  logic                   adc_switch_in,
  input  logic [(1<<SEL_W)-1:0]  dma_trig_in,
  input  logic                   waiting,
  input  logic [2:0]             mode,
  input  logic [SEL_W-1:0]       sel,
  input  logic                   share_on,
  output logic                   fire
);
  localparam int NDMA = 1 << SEL_W;

  logic            sw_pend, adc_pend;
  logic [NDMA-1:0] dma_pend;
  logic            want_sw, want_adc, want_dma, ready;

  assign want_sw  = (mode == TM_SW);
  assign want_adc = (mode == TM_ADC) && share_on;
  assign want_dma = (mode == TM_DMA);

  always_comb begin
    if (want_sw)       ready = sw_pend;
    else if (want_adc) ready = adc_pend;
    else if (want_dma) ready = dma_pend[sel];
    else               ready = 1'b1;
  end

  assign fire = waiting && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pend  <= 1'b0;
      adc_pend <= 1'b0;
    end else if (sreset) begin
      sw_pend  <= 1'b0;
      adc_pend <= 1'b0;
    end else begin
      sw_pend  <= (sw_pend  && !(fire && want_sw))  || sw_trig_in;
      adc_pend <= (adc_pend && !(fire && want_adc)) || adc_switch_in;
    end
  end

  for (genvar g = 0; g < NDMA; g++) begin : g_dma_pend
    logic take;
    assign take = fire && want_dma && (sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dma_pend[g] <= 1'b0;
      else if (sreset) dma_pend[g] <= 1'b0;
      else             dma_pend[g] <= (dma_pend[g] && !take) || dma_trig_in[g];
    end
  end
endmodule

// File: rtl/pset_walker.sv
module pset_walker
  import pset_pkg::*;
#(
  parameter int SETS_W = IDX_W,
  parameter int CNT_W  = LOOP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sreset,
  input  logic                   eng_on,
  input  logic [SETS_W-1:0]      start_idx,
  input  logic [SETS_W-1:0]      stop_idx,
  input  logic [CNT_W-1:0]       loop_val,
  output logic                   tbl_rd_en,
  output logic [SETS_W-1:0]      tbl_rd_addr,
  input  logic [$bits(set_cfg_t)-1:0] tbl_rd_data,
  output set_cfg_t               cfg,
  output logic                   waiting,
  input  logic                   fire,
  output logic                   calc_start,
  input  logic                   calc_done,
  output logic                   irq,
  output logic [(1<<CH_W)-1:0]   dma_chan_trig,
  output logic                   set_done,
  output logic [SETS_W-1:0]      done_idx,
  output logic                   busy
);
  seq_state_t        state;
  logic [SETS_W-1:0] idx;
  logic [CNT_W-1:0]  pass;

  assign tbl_rd_en   = (state == ST_FETCH);
  assign tbl_rd_addr = idx;
  assign waiting     = (state == ST_WAIT);
  assign set_done    = (state == ST_RUN) && calc_done && eng_on && !sreset;
  assign done_idx    = idx;
  assign busy        = (state == ST_FETCH) || (state == ST_LOAD) ||
                       (state == ST_WAIT)  || (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      idx           <= '0;
      pass          <= '0;
      cfg           <= '0;
      calc_start    <= 1'b0;
      irq           <= 1'b0;
      dma_chan_trig <= '0;
    end else if (sreset || !eng_on) begin
      state         <= ST_IDLE;
      pass          <= '0;
      calc_start    <= 1'b0;
      irq           <= 1'b0;
      dma_chan_trig <= '0;
    end else begin
      calc_start    <= 1'b0;
      irq           <= 1'b0;
      dma_chan_trig <= '0;
      unique case (state)
        ST_IDLE: begin
          idx   <= start_idx;
          pass  <= '0;
          state <= ST_FETCH;
        end
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          cfg   <= set_cfg_t'(tbl_rd_data);
          state <= ST_WAIT;
        end
        ST_WAIT: if (fire) begin
          calc_start <= 1'b1;
          state      <= ST_RUN;
        end
        ST_RUN: if (calc_done) begin
          irq           <= cfg.irq_en;
          dma_chan_trig <= cfg.dma_en ? chan_pulse(cfg.chan) : '0;
          if (idx == stop_idx) begin
            if (final_pass(pass, loop_val)) begin
              state <= ST_DONE;
            end else begin
              pass  <= CNT_W'(pass + 1'b1);
              idx   <= start_idx;
              state <= ST_FETCH;
            end
          end else begin
            idx   <= step_index(idx, start_idx, stop_idx);
            state <= ST_FETCH;
          end
        end
        ST_DONE: ;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pset_sequencer.sv
module pset_sequencer
  import pset_pkg::*;
#(
  parameter int SETS_W = IDX_W,
  parameter int SEL_W  = CH_W,
  parameter int CNT_W  = LOOP_W,
  parameter int AW     = REG_AW,
  parameter int DW     = REG_DW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr_en,
  input  logic [AW-1:0]               reg_addr,
  input  logic [DW-1:0]               reg_wdata,
  output logic                        tbl_rd_en,
  output logic [SETS_W-1:0]           tbl_rd_addr,
  input  logic [$bits(set_cfg_t)-1:0] tbl_rd_data,
  output logic                        calc_start,
  input  logic                        calc_done,
  input  logic                        sw_trig,
  input  logic                        adc_buf_switch,
  input  logic [(1<<SEL_W)-1:0]       dma_done_trig,
  output logic                        irq,
  output logic [(1<<SEL_W)-1:0]       dma_chan_trig,
  output logic                        busy,
  output logic [(1<<SETS_W)-1:0]      done_status
);
  logic              eng_on, share_on, sreset, clr_any;
  logic [SETS_W-1:0] start_idx, stop_idx, done_idx;
  logic [CNT_W-1:0]  loop_val;
  logic              set_done, waiting, fire;
  set_cfg_t          cfg;

  pset_ctrl_regs #(.SETS_W(SETS_W), .CNT_W(CNT_W), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .set_done(set_done), .done_idx(done_idx),
    .eng_on(eng_on), .share_on(share_on), .start_idx(start_idx),
    .stop_idx(stop_idx), .loop_val(loop_val), .done_bits(done_status),
    .sreset(sreset), .clr_any(clr_any)
  );

  pset_trig_unit #(.SEL_W(SEL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .sreset(sreset), .sw_trig_in(sw_trig),
    .adc_switch_in(adc_buf_switch), .dma_trig_in(dma_done_trig),
    .waiting(waiting), .mode(cfg.mode), .sel(cfg.sel),
    .share_on(share_on), .fire(fire)
  );

  pset_walker #(.SETS_W(SETS_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .sreset(sreset), .eng_on(eng_on),
    .start_idx(start_idx), .stop_idx(stop_idx), .loop_val(loop_val),
    .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr),
    .tbl_rd_data(tbl_rd_data), .cfg(cfg), .waiting(waiting), .fire(fire),
    .calc_start(calc_start), .calc_done(calc_done), .irq(irq),
    .dma_chan_trig(dma_chan_trig), .set_done(set_done),
    .done_idx(done_idx), .busy(busy)
  );
endmodule

// File: rtl/pset_sequencer_chk.sv
module pset_sequencer_chk #(
  parameter int NDONE = 16,
  parameter int NDMA  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             calc_start,
  input logic             calc_done,
  input logic             busy,
  input logic             irq,
  input logic [NDMA-1:0]  dma_chan_trig,
  input logic [NDONE-1:0] done_status,
  input logic             clr_any,
  input logic             eng_on
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    calc_start |=> !calc_start); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    calc_start |-> busy); // R9
  AST_DMA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_chan_trig)); // R6
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(calc_done)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_any) |-> ((done_status & $past(done_status)) == $past(done_status))); // R7
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_on |=> !busy); // R1
endmodule

bind pset_sequencer pset_sequencer_chk #(
  .NDONE(1 << SETS_W), .NDMA(1 << SEL_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .calc_start(calc_start), .calc_done(calc_done),
  .busy(busy), .irq(irq), .dma_chan_trig(dma_chan_trig),
  .done_status(done_status), .clr_any(clr_any), .eng_on(eng_on)
);

// File: tb/test_pset_sequencer.sv
module test_pset_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        tbl_rd_en;
  logic [3:0]  tbl_rd_addr;
  logic [12:0] tbl_rd_data = '0;
  logic        calc_start;
  logic        calc_done = 1'b0;
  logic        sw_trig = 1'b0;
  logic        adc_buf_switch = 1'b0;
  logic [15:0] dma_done_trig = '0;
  logic        irq;
  logic [15:0] dma_chan_trig;
  logic        busy;
  logic [15:0] done_status;

  int total = 0;
  int bad = 0;
  int starts = 0;
  int dly = 0;
  bit finished = 0;
  logic [12:0] mem [16];
  int fetch_log[$];
  logic [16:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pset_sequencer i_pset_sequencer (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr),
    .tbl_rd_data(tbl_rd_data), .calc_start(calc_start), .calc_done(calc_done),
    .sw_trig(sw_trig), .adc_buf_switch(adc_buf_switch),
    .dma_done_trig(dma_done_trig), .irq(irq), .dma_chan_trig(dma_chan_trig),
    .busy(busy), .done_status(done_status)
  );

  // table memory with one-cycle read latency
  always @(posedge clk) begin
    if (tbl_rd_en) begin
      tbl_rd_data <= mem[tbl_rd_addr];
      fetch_log.push_back(int'(tbl_rd_addr));
    end
  end

  // compute datapath model: done three cycles after start
  always @(negedge clk) begin
    calc_done = 1'b0;
    if (rst_n && calc_start) begin
      starts++;
      dly = 3;
    end else if (dly > 0) begin
      dly--;
      if (dly == 0) calc_done = 1'b1;
    end
  end

  function automatic logic [12:0] word(input logic [2:0] mode, input logic [3:0] sel,
                                       input logic ie, input logic de, input logic [3:0] ch);
    return {ch, de, ie, sel, mode};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_log(input string tag, input int exp[$]);
    total++;
    if (fetch_log != exp) begin
      bad++;
      $display("FAIL %s act=%p exp=%p", tag, fetch_log, exp);
    end
  endtask

  // scoreboard driver: expected completion pulse {irq, dma vector}
  task automatic expect_done(input logic ie, input logic de, input int ch);
    logic [15:0] v;
    v = de ? (16'h1 << ch) : 16'h0;
    if (ie || de) exp_q.push_back({ie, v});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (irq || dma_chan_trig != 0)) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6 unexpected act=%0h exp=none", {irq, dma_chan_trig});
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        if ({irq, dma_chan_trig} !== e) begin
          bad++;
          $display("FAIL R6 act=%0h exp=%0h", {irq, dma_chan_trig}, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
  endtask

  task automatic pulse_adc();
    @(negedge clk); adc_buf_switch = 1'b1; @(negedge clk); adc_buf_switch = 1'b0;
  endtask

  task automatic pulse_dma(input int b);
    @(negedge clk); dma_done_trig = 16'h1 << b; @(negedge clk); dma_done_trig = '0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset irq/dma", {irq, dma_chan_trig}, 0);
    chk("R1 reset done", done_status, 0);
    chk("R1 reset start", calc_start, 0);

    // wrong enable code
    wr(3'd0, 16'h0006);
    cycles(20);
    chk("R1 enable 110 no start", starts, 0);
    chk("R1 enable 110 idle", busy, 0);

    // modes immediate, sw, dma, immediate
    mem[0] = word(3'b000, 4'd0, 1'b1, 1'b0, 4'd0);
    mem[1] = word(3'b001, 4'd0, 1'b0, 1'b1, 4'd5);
    mem[2] = word(3'b011, 4'd9, 1'b1, 1'b1, 4'd15);
    mem[3] = word(3'b100, 4'd0, 1'b0, 1'b0, 4'd0);
    wr(3'd2, 16'h0030);
    wr(3'd3, 16'h0000);
    expect_done(1'b1, 1'b0, 0);
    expect_done(1'b0, 1'b1, 5);
    expect_done(1'b1, 1'b1, 15);
    wr(3'd0, 16'h0007);
    cycles(40);
    chk("R4 sw mode waits", starts, 1);
    chk("R9 busy while waiting", busy, 1);
    pulse_sw();
    cycles(40);
    chk("R4 sw trigger launches", starts, 2);
    pulse_dma(3);
    cycles(30);
    chk("R4 wrong dma bit ignored", starts, 2);
    pulse_dma(9);
    cycles(40);
    chk("R4 dma bit launches", starts, 4);
    chk("R9 busy drops at end", busy, 0);
    chk("R7 done bits", done_status, 16'h000F);
    chk_log("R2 order 0..3", '{0, 1, 2, 3});

    // wrap 14..1, two passes, one dma pulse per run
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h000F);
    cycles(2);
    chk("R7 w1c clears", done_status, 0);
    mem[14] = word(3'b000, 4'd0, 1'b1, 1'b0, 4'd0);
    mem[15] = word(3'b011, 4'd9, 1'b1, 1'b0, 4'd0);
    mem[0]  = word(3'b000, 4'd0, 1'b0, 1'b0, 4'd0);
    mem[1]  = word(3'b000, 4'd0, 1'b0, 1'b0, 4'd0);
    wr(3'd2, 16'h001E);
    wr(3'd3, 16'h0002);
    fetch_log.delete();
    repeat (4) expect_done(1'b1, 1'b0, 0);
    pulse_dma(9);
    base = starts;
    wr(3'd0, 16'h0007);
    cycles(60);
    chk_log("R5 one pulse one run", '{14, 15, 0, 1, 14, 15});
    chk("R5 second run held", starts - base, 5);
    pulse_dma(9);
    cycles(60);
    chk_log("R2 R3 wrap and two passes", '{14, 15, 0, 1, 14, 15, 0, 1});
    chk("R3 finished after passes", busy, 0);
    chk("R7 done after wrap", done_status, 16'hC003);
    wr(3'd4, 16'h8000);
    cycles(2);
    chk("R7 single bit clear", done_status, 16'h4003);

    // adc mode with and without sharing
    wr(3'd0, 16'h0000);
    mem[4] = word(3'b010, 4'd0, 1'b1, 1'b0, 4'd0);
    wr(3'd2, 16'h0044);
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0000);
    expect_done(1'b1, 1'b0, 0);
    base = starts;
    wr(3'd0, 16'h0007);
    cycles(30);
    chk("R4 adc mode unshared runs at once", starts - base, 1);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0001);
    expect_done(1'b1, 1'b0, 0);
    wr(3'd0, 16'h0007);
    cycles(30);
    chk("R4 adc mode shared waits", starts - base, 1);
    pulse_adc();
    cycles(30);
    chk("R4 adc switch launches", starts - base, 2);

    // endless loop and software reset
    wr(3'd0, 16'h0000);
    mem[5] = '0;
    wr(3'd2, 16'h0055);
    wr(3'd3, 16'h0FFF);
    base = starts;
    wr(3'd0, 16'h0007);
    cycles(200);
    chk("R3 endless loop keeps running", (starts - base) >= 15, 1);
    chk("R3 endless loop busy", busy, 1);
    wr(3'd5, 16'h0007);
    wr(3'd5, 16'h0001);
    wr(3'd5, 16'h0000);
    cycles(5);
    chk("R8 broken sequence no reset", busy, 1);
    wr(3'd5, 16'h0007);
    wr(3'd5, 16'h0000);
    cycles(3);
    chk("R8 reset stops engine", busy, 0);
    chk("R8 reset clears done", done_status, 0);
    base = starts;
    cycles(30);
    chk("R8 enable cleared", starts - base, 0);
    chk("R6 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule